// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data buses, called A and B. Each transfer direction has its own storage register, loaded by its own capture strobe. An active-low output enable and a direction input choose which bus, if any, the block drives. A select input for each direction chooses what the driven bus receives: either the live value on the opposite bus or the contents of that direction's storage register. The storage registers load on every strobe, whatever the enable and direction inputs are. This allows data to be parked while both buses are isolated and replayed later.

Each bus is modelled at the block edge as three vectors: an input, an output and a per-bit output enable. Tri-state resolution is left to the pad ring. The two capture strobes are single-cycle pulses in the single system clock domain. Every output comes straight from a flop, so switching between stored and live data cannot cause a decode glitch. A parameter chooses true or complemented output data.

Top module: `xbus_reg_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both storage registers and drives all four output vectors to zero from that edge on.
- R2: The A-side register loads `a_in` at each clock edge where `cap_ab` is 1 and holds its value otherwise. It is read through `b_out` with `sel_ab` = 1.
- R3: The B-side register loads `b_in` at each clock edge where `cap_ba` is 1 and holds its value otherwise. It is read through `a_out` with `sel_ba` = 1.
- R4: Register loading does not depend on `oe_n` or `dir`. Data captured while both buses are isolated is the data replayed later.
- R5: When `oe_n` = 1 at an edge, both `a_oe` and `b_oe` are all zeros after that edge, and so are `a_out` and `b_out`.
- R6: When `oe_n` = 0 at an edge, `dir` = 0 makes `a_oe` all ones and `b_oe` all zeros after that edge. `dir` = 1 makes `b_oe` all ones and `a_oe` all zeros.
- R7: While B is driven, `sel_ab` = 0 makes `b_out` equal `a_in` as sampled at the previous edge. `sel_ab` = 1 makes it equal the A-side register value as of that edge, including a capture made at that same edge.
- R8: While A is driven, `sel_ba` = 0 makes `a_out` equal `b_in` as sampled at the previous edge. `sel_ba` = 1 makes it equal the B-side register value as of that edge. The outputs of a bus that is not driven are zero.
- R9: `a_oe` and `b_oe` are each either all zeros or all ones, and they are never both non-zero.
- R10: With `INVERT` = 1, every non-zero driven data value is the bitwise complement of the value that R7 and R8 give.
- R11: All outputs change only at rising clock edges, with exactly one cycle of latency from the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| cap_ab | input | 1 | Capture strobe for the A-side register |
| cap_ba | input | 1 | Capture strobe for the B-side register |
| sel_ab | input | 1 | 1 sends stored A data to B, 0 sends live A data |
| sel_ba | input | 1 | 1 sends stored B data to A, 0 sends live B data |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Data driven onto bus A |
| a_oe | output | W | Per-bit enable for bus A drivers |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Data driven onto bus B |
| b_oe | output | W | Per-bit enable for bus B drivers |

## Verification
The properties assume that reset is held for at least one edge before any check counts. They also assume that every control input is a clean 0 or 1 at each edge. The output properties compare against the previous edge's inputs and are gated off for the first cycle after reset. The stimulus drives all inputs only on the falling edge and holds reset for several edges at start-up. It then sweeps all 64 combinations of the six control inputs against several data patterns, so every input is stable and known whenever a rising edge samples it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_TO_A = 2'd1,
    ROUTE_TO_B = 2'd2
  } route_e;

endpackage

// File: rtl/xbus_store.sv
module xbus_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);

  // next value is exported so the output stage can show a capture made
  // at the same edge without an extra cycle of delay
  always_comb begin
    nxt = cap ? din : q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output route_e route
);

  always_comb begin
    if (oe_n) begin
      route = ROUTE_NONE;
    end else if (dir) begin
      route = ROUTE_TO_B;
    end else begin
      route = ROUTE_TO_A;
    end
  end

endmodule

// File: rtl/xbus_port.sv
module xbus_port #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drive,
  input  logic         sel_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored_nxt,
  output logic [W-1:0] dout,
  output logic [W-1:0] doe
);

  logic [W-1:0] pick;
  logic [W-1:0] shaped;
  logic [W-1:0] dout_d;

  always_comb begin
    pick = sel_stored ? stored_nxt : live;
  end

  generate
    if (INVERT) begin : g_inv
      always_comb shaped = ~pick;
    end else begin : g_true
      always_comb shaped = pick;
    end
  endgenerate

  always_comb begin
    dout_d = drive ? shaped : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      doe  <= '0;
    end else begin
      dout <= dout_d;
      doe  <= {W{drive}};
    end
  end

endmodule

// File: rtl/xbus_reg_xcvr.sv
module xbus_reg_xcvr
  import xbus_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  route_e       route;
  logic [W-1:0] st_a_nxt, st_a_q;
  logic [W-1:0] st_b_nxt, st_b_q;
  logic         drv_a, drv_b;

  xbus_route u_route (
    .oe_n  (oe_n),
    .dir   (dir),
    .route (route)
  );

  assign drv_a = (route == ROUTE_TO_A);
  assign drv_b = (route == ROUTE_TO_B);

  xbus_store #(.W(W)) u_store_a (
    .clk (clk),
    .rst (rst),
    .cap (cap_ab),
    .din (a_in),
    .nxt (st_a_nxt),
    .q   (st_a_q)
  );

  xbus_store #(.W(W)) u_store_b (
    .clk (clk),
    .rst (rst),
    .cap (cap_ba),
    .din (b_in),
    .nxt (st_b_nxt),
    .q   (st_b_q)
  );

  // bus B is fed from the A side
  xbus_port #(.W(W), .INVERT(INVERT)) u_port_b (
    .clk        (clk),
    .rst        (rst),
    .drive      (drv_b),
    .sel_stored (sel_ab),
    .live       (a_in),
    .stored_nxt (st_a_nxt),
    .dout       (b_out),
    .doe        (b_oe)
  );

  // bus A is fed from the B side
  xbus_port #(.W(W), .INVERT(INVERT)) u_port_a (
    .clk        (clk),
    .rst        (rst),
    .drive      (drv_a),
    .sel_stored (sel_ba),
    .live       (b_in),
    .stored_nxt (st_b_nxt),
    .dout       (a_out),
    .doe        (a_oe)
  );

endmodule

// File: rtl/xbus_reg_xcvr_chk.sv
module xbus_reg_xcvr_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe
);

  logic live_ok;
  always_ff @(posedge clk) begin
    if (rst) live_ok <= 1'b0;
    else     live_ok <= 1'b1;
  end

  function automatic logic [W-1:0] shape(input logic [W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  // R9
  a_r9_one_bus: assert property (@(posedge clk) disable iff (rst)
    !((|a_oe) && (|b_oe)));

  // R9
  a_r9_uniform: assert property (@(posedge clk) disable iff (rst)
    ((a_oe == '0) || (a_oe == '1)) && ((b_oe == '0) || (b_oe == '1)));

  // R5
  a_r5_isolated: assert property (@(posedge clk) disable iff (rst)
    live_ok && $past(oe_n) |-> (a_oe == '0) && (b_oe == '0) && (a_out == '0) && (b_out == '0));

  // R6
  a_r6_drive_a: assert property (@(posedge clk) disable iff (rst)
    live_ok && !$past(oe_n) && !$past(dir) |-> (a_oe == '1) && (b_oe == '0));

  // R6
  a_r6_drive_b: assert property (@(posedge clk) disable iff (rst)
    live_ok && !$past(oe_n) && $past(dir) |-> (b_oe == '1) && (a_oe == '0));

  // R7
  a_r7_live_ab: assert property (@(posedge clk) disable iff (rst)
    live_ok && !$past(oe_n) && $past(dir) && !$past(sel_ab) |-> b_out == shape($past(a_in)));

  // R8
  a_r8_live_ba: assert property (@(posedge clk) disable iff (rst)
    live_ok && !$past(oe_n) && !$past(dir) && !$past(sel_ba) |-> a_out == shape($past(b_in)));

endmodule

bind xbus_reg_xcvr xbus_reg_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .oe_n   (oe_n),
  .dir    (dir),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba),
  .a_in   (a_in),
  .b_in   (b_in),
  .a_out  (a_out),
  .a_oe   (a_oe),
  .b_out  (b_out),
  .b_oe   (b_oe)
);

// File: tb/xbus_reg_xcvr_tb.sv
module xbus_reg_xcvr_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         oe_n = 1'b1, dir = 1'b0;
  logic         cap_ab = 1'b0, cap_ba = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] ia_out, ia_oe, ib_out, ib_oe;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic [W-1:0] m_sa = '0, m_sb = '0;
  logic [W-1:0] e_aout, e_aoe, e_bout, e_boe;

  always #10 clk = ~clk;

  xbus_reg_xcvr #(.W(W), .INVERT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  xbus_reg_xcvr #(.W(W), .INVERT(1'b1)) u_inv (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
    .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected outputs from current inputs and model state; called before the edge
  task automatic predict();
    logic [W-1:0] na, nb;
    na = cap_ab ? a_in : m_sa;
    nb = cap_ba ? b_in : m_sb;
    e_aout = '0; e_bout = '0; e_aoe = '0; e_boe = '0;
    if (!oe_n && !dir) begin
      e_aoe  = '1;
      e_aout = sel_ba ? nb : b_in;
    end
    if (!oe_n && dir) begin
      e_boe  = '1;
      e_bout = sel_ab ? na : a_in;
    end
    m_sa = na;
    m_sb = nb;
  endtask

  task automatic compare();
    string ra, rb;
    ra = sel_ba ? "R3" : "R8";
    rb = sel_ab ? "R2" : "R7";
    if (oe_n) begin
      ra = "R5"; rb = "R5";
    end
    check(oe_n ? "R5" : "R6", "a_oe", a_oe, e_aoe);
    check(oe_n ? "R5" : "R6", "b_oe", b_oe, e_boe);
    check("R9", "both_oe", {{(W-1){1'b0}}, (|a_oe) && (|b_oe)}, '0);
    check(ra, "a_out", a_out, e_aout);
    check(rb, "b_out", b_out, e_bout);
    check("R10", "inv a_out", ia_out, (e_aoe != '0) ? ~e_aout : '0);
    check("R10", "inv b_out", ib_out, (e_boe != '0) ? ~e_bout : '0);
    check("R10", "inv a_oe", ia_oe, e_aoe);
  endtask

  // inputs already set (after a negedge); clock one edge and check at next negedge
  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input logic o, input logic d, input logic ca, input logic cb,
                       input logic sa, input logic sb,
                       input logic [W-1:0] av, input logic [W-1:0] bv);
    oe_n = o; dir = d; cap_ab = ca; cap_ba = cb; sel_ab = sa; sel_ba = sb;
    a_in = av; b_in = bv;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    // R1: outputs cleared while reset is held
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "a_out", a_out, '0);
    check("R1", "b_out", b_out, '0);
    check("R1", "a_oe", a_oe, '0);
    check("R1", "b_oe", b_oe, '0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    rst = 1'b0;
    // R1: registers cleared, seen through stored readback
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h66);
    step();
    check("R1", "store_a after reset", b_out, 8'h00);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h66);
    step();
    check("R1", "store_b after reset", a_out, 8'h00);

    // R4: capture during isolation, then replay
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, 8'h5E);
    step();
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22);
    step();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h99, 8'h88);
    step();
    check("R4", "replay A store", b_out, 8'hC3);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h99, 8'h88);
    step();
    check("R4", "replay B store", a_out, 8'h5E);

    // R2: same-edge capture is shown at once
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h4D, 8'h00);
    step();
    check("R2", "same-edge capture", b_out, 8'h4D);

    // R11: outputs hold between edges when inputs change
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h0F);
    #5;
    check("R11", "b_out stable mid-cycle", b_out, 8'h4D);
    check("R11", "b_oe stable mid-cycle", b_oe, '1);
    step();
    check("R11", "b_out after edge", b_out, 8'hF0);

    // sweep of all control combinations over several data patterns
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 64; c++) begin
        logic [5:0] k;
        logic [W-1:0] av, bv;
        k  = c[5:0];
        av = W'((c * 37 + p * 101 + 5) & 255);
        bv = W'(((c * 91 + p * 29 + 13) & 255) ^ 8'h5A);
        drive(k[0], k[1], k[2], k[3], k[4], k[5], av, bv);
        step();
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule